// File: doc/BRIEF.md
# Regex instruction sequencer

This block walks a program of pattern-matching instructions held in a small instruction memory. Each cycle in which the data side presents a compare result, it evaluates the instruction at the current program counter against that one success/fail bit. It then picks the next program counter and tells the surrounding logic three things: whether the current input characters were consumed, whether the whole attempt must start over, and whether a complete pattern has been recognised.

The instruction set covers plain compare, alternation as a conditional relative branch, and zero-or-more, one-or-more and optional repetition of a short operand. A report instruction carries a pattern identifier. The character operand, its length and the instruction's failure flag are presented on outputs for the comparator and for a separate data-address controller. Any decision about moving the data pointer backwards belongs to that controller.

Top module: `rx_seq_top`

## Requirements
- R1: While reset is asserted and until the synchronised release completes, `imem_addr` is 0 and `advance`, `restart` and `match_vld` are low.
- R2: The instruction word at `imem_addr` is split as follows: bits 31:28 opcode, bit 27 failure flag (`op_fbit`), bits 26:24 operand length (`op_len`), bits 23:8 operand (`op_chars`) and bits 7:0 signed offset. The three operand-side outputs follow the current word combinationally.
- R3: Opcode 1 (compare): a hit advances the PC by one with `advance` high. A miss raises `restart` and sends the PC to 0.
- R4: Opcode 2 (alternate): a hit advances the PC by one with `advance` high. A miss does not consume; the PC becomes the current PC plus the sign-extended offset, modulo the program size.
- R5: Opcode 3 (zero-or-more): a hit keeps the PC and consumes. A miss moves to PC+1 without consuming and without restart.
- R6: Opcode 4 (one-or-more): a hit keeps the PC and consumes. A miss after at least one hit on this instruction moves to PC+1 without consuming. A miss on the first attempt raises `restart` and sends the PC to 0.
- R7: Opcode 5 (optional): the PC always moves to PC+1, and `advance` equals the compare result.
- R8: Opcode 6 (report): `match_vld` is high, `match_id` equals operand bits 7:0, and `advance` and `restart` are low whatever `cmp_hit` is. The PC is 0 on the next cycle.
- R9: Any other opcode (0 or 7 to 15) raises `restart`, consumes nothing and sends the PC to 0.
- R10: With `step` low, the PC and the one-or-more history are held, and `advance`, `restart` and `match_vld` are low.
- R11: The PC wraps modulo the program size when it steps past the last instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step | input | 1 | A compare result is present this cycle; evaluate the current instruction |
| cmp_hit | input | 1 | Comparator success for the current operand |
| imem_addr | output | AW (4) | Instruction memory read address (the program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational read |
| op_chars | output | 16 | Current operand characters |
| op_len | output | 3 | Current operand length |
| op_fbit | output | 1 | Failure flag of the current instruction |
| advance | output | 1 | Input characters consumed this step |
| restart | output | 1 | Attempt failed; sequence restarts at instruction 0 |
| match_vld | output | 1 | A report instruction executed this step |
| match_id | output | 8 | Pattern identifier, valid with `match_vld` |

## Verification
The assertions assume the instruction memory answers combinationally in the same cycle, so that `imem_rdata` always holds the word at the current `imem_addr`. They also assume `step` is a clean per-cycle qualifier from the comparator. The bench keeps to this by modelling the memory as a combinational array lookup. It changes `step`, `cmp_hit` and memory contents only at the falling edge, never between an address change and the following rising edge. Every opcode value is reached at every nonzero PC through an alternation branch, both with a hit and with a miss.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;

  localparam int IW = 32;

  localparam logic [3:0] OP_CMP   = 4'h1;
  localparam logic [3:0] OP_ALT   = 4'h2;
  localparam logic [3:0] OP_STAR  = 4'h3;
  localparam logic [3:0] OP_PLUS  = 4'h4;
  localparam logic [3:0] OP_OPT   = 4'h5;
  localparam logic [3:0] OP_MATCH = 4'h6;

  // field order is decoded by the compiler side, keep it fixed
  typedef struct packed {
    logic [3:0]  op;
    logic        fbit;
    logic [2:0]  len;
    logic [15:0] chars;
    logic [7:0]  off;
  } rx_instr_t;

  typedef enum logic [1:0] {
    GO_NEXT = 2'd0,
    GO_STAY = 2'd1,
    GO_JUMP = 2'd2,
    GO_HOME = 2'd3
  } rx_go_e;

endpackage

// File: rtl/rx_seq_decode.sv
module rx_seq_decode
  import rx_seq_pkg::*;
(
  input  logic [IW-1:0] word,
  output rx_instr_t     ins,
  output logic          legal
);
  always_comb begin
    ins = rx_instr_t'(word);
    unique case (ins.op)
      OP_CMP, OP_ALT, OP_STAR, OP_PLUS, OP_OPT, OP_MATCH: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_seq_step.sv
module rx_seq_step
  import rx_seq_pkg::*;
#(
  parameter int AW = 4
) (
  input  rx_instr_t       ins,
  input  logic            legal,
  input  logic [AW-1:0]   pc,
  input  logic            hit,
  input  logic            seen,
  output logic [AW-1:0]   pc_nxt,
  output logic            seen_nxt,
  output logic            adv,
  output logic            home_req,
  output logic            rpt
);
  localparam int EW = (AW > 8) ? AW : 8;

  rx_go_e         go;
  logic [EW-1:0]  off_x;
  logic [AW-1:0]  pc_inc;
  logic [AW-1:0]  pc_jmp;

  always_comb begin
    off_x  = EW'($signed(ins.off));
    pc_inc = pc + AW'(1);
    pc_jmp = pc + off_x[AW-1:0];
  end

  always_comb begin
    go       = GO_HOME;
    adv      = 1'b0;
    home_req = 1'b0;
    rpt      = 1'b0;
    if (!legal) begin
      home_req = 1'b1;
    end else begin
      unique case (ins.op)
        OP_CMP: begin
          adv      = hit;
          go       = hit ? GO_NEXT : GO_HOME;
          home_req = !hit;
        end
        OP_ALT: begin
          adv = hit;
          go  = hit ? GO_NEXT : GO_JUMP;
        end
        OP_STAR: begin
          adv = hit;
          go  = hit ? GO_STAY : GO_NEXT;
        end
        OP_PLUS: begin
          adv = hit;
          if (hit)       go = GO_STAY;
          else if (seen) go = GO_NEXT;
          else begin
            go       = GO_HOME;
            home_req = 1'b1;
          end
        end
        OP_OPT: begin
          adv = hit;
          go  = GO_NEXT;
        end
        default: begin
          rpt = 1'b1;
          go  = GO_HOME;
        end
      endcase
    end
  end

  always_comb begin
    unique case (go)
      GO_NEXT: pc_nxt = pc_inc;
      GO_STAY: pc_nxt = pc;
      GO_JUMP: pc_nxt = pc_jmp;
      default: pc_nxt = '0;
    endcase
    seen_nxt = legal && (ins.op == OP_PLUS) && hit;
  end
endmodule

// File: rtl/rx_seq_top.sv
module rx_seq_top
  import rx_seq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          cmp_hit,
  output logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_rdata,
  output logic [15:0]   op_chars,
  output logic [2:0]    op_len,
  output logic          op_fbit,
  output logic          advance,
  output logic          restart,
  output logic          match_vld,
  output logic [7:0]    match_id
);
  logic [1:0]    rst_sync;
  logic          live;
  logic          en;
  logic [AW-1:0] pc_q, pc_d;
  logic          seen_q, seen_d;
  rx_instr_t     ins;
  logic          legal;
  logic          adv_w, home_w, rpt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  always_comb begin
    live = rst_sync[1];
    en   = live && step;
  end

  rx_seq_decode u_dec (
    .word  (imem_rdata),
    .ins   (ins),
    .legal (legal)
  );

  rx_seq_step #(.AW(AW)) u_step (
    .ins      (ins),
    .legal    (legal),
    .pc       (pc_q),
    .hit      (cmp_hit),
    .seen     (seen_q),
    .pc_nxt   (pc_d),
    .seen_nxt (seen_d),
    .adv      (adv_w),
    .home_req (home_w),
    .rpt      (rpt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      seen_q <= 1'b0;
    end else if (en) begin
      pc_q   <= pc_d;
      seen_q <= seen_d;
    end
  end

  always_comb begin
    imem_addr = pc_q;
    op_chars  = ins.chars;
    op_len    = ins.len;
    op_fbit   = ins.fbit;
    match_id  = ins.chars[7:0];
    advance   = en && adv_w;
    restart   = en && home_w;
    match_vld = en && rpt_w;
  end
endmodule

// File: rtl/rx_seq_chk.sv
module rx_seq_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [AW-1:0] imem_addr,
  input logic [31:0]   imem_rdata,
  input logic          advance,
  input logic          restart,
  input logic          match_vld
);
  // R3
  restart_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (imem_addr == '0));

  // R8
  match_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |=> (imem_addr == '0));

  // R8
  match_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> (!advance && !restart));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(imem_addr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !(advance || restart || match_vld));

  // R5
  star_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && imem_rdata[31:28] == 4'h3) |=> $stable(imem_addr));
endmodule

bind rx_seq_top rx_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_rx_seq_top.sv
`timescale 1ns/1ps
module tb_rx_seq_top;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          step;
  logic          cmp_hit;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic [15:0]   op_chars;
  logic [2:0]    op_len;
  logic          op_fbit;
  logic          advance;
  logic          restart;
  logic          match_vld;
  logic [7:0]    match_id;
  logic [31:0]   mem [N];

  int n_chk;
  int n_bad;
  bit done;

  rx_seq_top #(.AW(AW)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb imem_rdata = mem[imem_addr];

  function automatic logic [31:0] enc(input logic [3:0] op, input logic f,
      input logic [2:0] len, input logic [15:0] ch, input logic [7:0] off);
    return {op, f, len, ch, off};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < N; i++) mem[i] = 32'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    step = 1'b0; cmp_hit = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drive one evaluated step; outputs are sampled before the rising edge
  task automatic go(input logic h);
    step = 1'b1; cmp_hit = h;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    step = 1'b0; cmp_hit = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    step = 1'b0; cmp_hit = 1'b0; rst_n = 1'b0;
    clear_mem();
    #1;
    // R1 during reset
    check("R1 pc in reset", int'(imem_addr), 0);
    check("R1 flags in reset", int'({advance, restart, match_vld}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step = 1'b1; cmp_hit = 1'b1;
    #1;
    // R1 synchronised release still pending: outputs quiet
    check("R1 flags during release", int'({advance, restart, match_vld}), 0);
    step = 1'b0;

    // sweep every opcode at every nonzero PC with hit and miss
    for (int t = 1; t < N; t++) begin
      for (int op = 0; op < 16; op++) begin
        for (int h = 0; h < 2; h++) begin
          logic [15:0] ch;
          int exp_pc, exp_adv, exp_rs, exp_m;
          ch = {4'hA, 4'(t), 4'(op), 4'(h)};
          clear_mem();
          mem[0] = enc(4'h2, 1'b0, 3'd0, 16'h0, 8'(t));
          mem[t] = enc(4'(op), 1'(t), 3'(t % 5), ch, 8'hFD);
          do_reset();
          check("R1 pc after reset", int'(imem_addr), 0);
          go(1'b0);
          // R4 miss at alternate: no consume, no restart
          check("R4 alt miss flags", int'({advance, restart, match_vld}), 0);
          settle();
          check("R4 alt branch target", int'(imem_addr), t);
          exp_adv = 0; exp_rs = 0; exp_m = 0;
          case (op)
            1: begin exp_pc = h ? (t + 1) % N : 0; exp_adv = h; exp_rs = !h; end
            2: begin exp_pc = h ? (t + 1) % N : (t - 3 + N) % N; exp_adv = h; end
            3: begin exp_pc = h ? t : (t + 1) % N; exp_adv = h; end
            4: begin exp_pc = h ? t : 0; exp_adv = h; exp_rs = !h; end
            5: begin exp_pc = (t + 1) % N; exp_adv = h; end
            6: begin exp_pc = 0; exp_m = 1; end
            default: begin exp_pc = 0; exp_rs = 1; end
          endcase
          go(1'(h));
          check("R2 fbit", int'(op_fbit), t % 2);
          check("R2 len", int'(op_len), t % 5);
          check("R2 chars", int'(op_chars), int'(ch));
          if (op == 1) check("R3 cmp flags", int'({advance, restart}), exp_adv * 2 + exp_rs);
          else if (op == 2) check("R4 alt flags", int'({advance, restart}), exp_adv * 2 + exp_rs);
          else if (op == 3) check("R5 star flags", int'({advance, restart}), exp_adv * 2 + exp_rs);
          else if (op == 4) check("R6 plus flags", int'({advance, restart}), exp_adv * 2 + exp_rs);
          else if (op == 5) check("R7 opt flags", int'({advance, restart}), exp_adv * 2 + exp_rs);
          else if (op == 6) begin
            check("R8 report flags", int'({advance, restart, match_vld}), 1);
            check("R8 report id", int'(match_id), int'(ch[7:0]));
          end else check("R9 illegal flags", int'({advance, restart, match_vld}), 2);
          if (op != 6) check("R8 no report", int'(match_vld), exp_m);
          settle();
          if (t == N - 1 && (op == 1 || op == 5) && h == 1)
            check("R11 wrap", int'(imem_addr), exp_pc);
          else
            check($sformatf("R3-opcode%0d next pc", op), int'(imem_addr), exp_pc);
        end
      end
    end

    // R6 with history, and history cleared on leaving; R10 hold keeps history
    clear_mem();
    mem[0] = enc(4'h2, 1'b0, 3'd0, 16'h0, 8'd2);
    mem[2] = enc(4'h4, 1'b1, 3'd2, 16'h6162, 8'd0);
    mem[3] = enc(4'h4, 1'b0, 3'd1, 16'h0063, 8'd0);
    do_reset();
    go(1'b0); settle();
    go(1'b1); check("R6 first hit consumes", int'(advance), 1); settle();
    check("R6 stays on hit", int'(imem_addr), 2);
    for (int k = 0; k < 3; k++) begin
      step = 1'b0; cmp_hit = 1'(k); #1;
      check("R10 idle flags", int'({advance, restart, match_vld}), 0);
      @(negedge clk);
      check("R10 idle pc hold", int'(imem_addr), 2);
    end
    go(1'b0);
    check("R6 miss after hit no restart", int'({advance, restart}), 0);
    settle();
    check("R6 miss after hit moves on", int'(imem_addr), 3);
    go(1'b0);
    check("R6 first attempt miss restarts", int'(restart), 1);
    settle();
    check("R6 restart pc", int'(imem_addr), 0);

    // R5 repeated hits stay, then fall through
    clear_mem();
    mem[0] = enc(4'h3, 1'b0, 3'd1, 16'h0078, 8'd0);
    mem[1] = enc(4'h6, 1'b1, 3'd0, 16'h005A, 8'd0);
    do_reset();
    for (int k = 0; k < 4; k++) begin
      go(1'b1); settle();
      check("R5 star repeat stays", int'(imem_addr), 0);
    end
    go(1'b0); check("R5 star miss no consume", int'({advance, restart}), 0); settle();
    check("R5 star falls through", int'(imem_addr), 1);
    go(1'b1);
    check("R8 report ignores hit", int'({advance, restart, match_vld}), 1);
    check("R8 report id", int'(match_id), 8'h5A);
    settle();
    check("R8 pc home after report", int'(imem_addr), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule